// File: doc/BRIEF.md
# ADC Result Compare Window Filter

This block sits after a converter's result path and decides whether each finished conversion is kept. Every result arrives with a one-cycle valid strobe. When the compare function is off, each result is kept. When it is on, the result is tested against two programmable thresholds under one of four conditions. A result that passes raises a one-cycle accept strobe and is written into the held-result register. A result that fails produces no strobe, and the held result keeps its previous content.

The four conditions are chosen by a greater-than bit and a range bit. The two range conditions change shape with the order of the thresholds. When threshold A is at or below threshold B, the range conditions test a window. When A is above B, the same conditions test the complementary band. Results from a differential conversion are two's complement and compare signed. Single-ended results compare unsigned. When hardware averaging is in use, only the final averaged value is presented here.

Top module: `adc_window_gate`

## Requirements
- R1: During and straight after reset, `accept` is 0 and `result_q` is all zeros.
- R2: A result is judged in the cycle its `res_valid` is high. On a pass, `accept` is high for exactly the next cycle and `result_q` then holds that result.
- R3: With `cmp_en` low, every valid result is accepted, whatever the mode bits and thresholds.
- R4: With `cmp_en` high, `cmp_gt`=0 and `cmp_rng`=0 (mode value 0), a result passes only if it is strictly less than `thr_a`.
- R5: With `cmp_gt`=1 and `cmp_rng`=0 (mode value 1), a result passes only if it is strictly greater than `thr_a`.
- R6: With `cmp_gt`=0, `cmp_rng`=1 (mode value 2) and `thr_a` <= `thr_b`, a result passes if it is below `thr_a` or above `thr_b`.
- R7: With mode value 2 and `thr_a` > `thr_b`, a result passes only if it is below `thr_a` and above `thr_b`.
- R8: With `cmp_gt`=1, `cmp_rng`=1 (mode value 3) and `thr_a` <= `thr_b`, a result passes only if it is above `thr_a` and below `thr_b`.
- R9: With mode value 3 and `thr_a` > `thr_b`, a result passes if it is above `thr_a` or below `thr_b`.
- R10: A failing result gives no `accept` pulse, and `result_q` keeps its previous value.
- R11: With `diff_mode`=1, the result and both thresholds are two's complement and compare signed. With `diff_mode`=0, they compare unsigned.
- R12: In a cycle with `res_valid` low, no result is taken, even with compare off. The next cycle has `accept` low and `result_q` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | DATA_W | Conversion result |
| diff_mode | input | 1 | 1: signed (differential) compare, 0: unsigned |
| cmp_en | input | 1 | Compare function enable |
| cmp_gt | input | 1 | Greater-than select (mode bit 0) |
| cmp_rng | input | 1 | Range select (mode bit 1) |
| thr_a | input | DATA_W | Threshold A |
| thr_b | input | DATA_W | Threshold B |
| accept | output | 1 | One-cycle pulse: result was kept |
| result_q | output | DATA_W | Held result |

## Verification
The bench builds the block with DATA_W = 4, which makes the whole space of result and both thresholds only 4096 points. Every point is run in all four modes under both signed and unsigned compare. This covers every ordering of the thresholds, including equal thresholds and the sign-bit crossing in signed mode. Short sweeps with compare off, and idle cycles with changing data, cover the bypass and hold behaviour.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

  // Mode value is {cmp_rng, cmp_gt}; the range bit is the upper bit.
  typedef enum logic [1:0] {
    WIN_BELOW   = 2'd0,
    WIN_ABOVE   = 2'd1,
    WIN_OUTSIDE = 2'd2,
    WIN_INSIDE  = 2'd3
  } win_mode_e;

  function automatic win_mode_e win_mode(input logic rng, input logic gt);
    return win_mode_e'({rng, gt});
  endfunction

endpackage

// File: rtl/adc_win_cmp.sv
module adc_win_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              diff_mode,
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] thr_a,
  input  logic [DATA_W-1:0] thr_b,
  output logic              v_lt_a,
  output logic              v_gt_a,
  output logic              v_lt_b,
  output logic              v_gt_b,
  output logic              a_le_b
);
  localparam int EXT_W = DATA_W + 1;
  localparam int N_OPS = 3;

  // Extend by one bit: sign copy for signed mode, zero otherwise,
  // so a single signed comparator serves both encodings.
  function automatic logic signed [EXT_W-1:0] widen(input logic [DATA_W-1:0] x,
                                                    input logic is_signed);
    return {is_signed & x[DATA_W-1], x};
  endfunction

  logic [DATA_W-1:0]       op_raw [N_OPS];
  logic signed [EXT_W-1:0] op_ext [N_OPS];

  assign op_raw[0] = val;
  assign op_raw[1] = thr_a;
  assign op_raw[2] = thr_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_ext
    assign op_ext[g] = widen(op_raw[g], diff_mode);
  end

  assign v_lt_a = op_ext[0] < op_ext[1];
  assign v_gt_a = op_ext[0] > op_ext[1];
  assign v_lt_b = op_ext[0] < op_ext[2];
  assign v_gt_b = op_ext[0] > op_ext[2];
  assign a_le_b = op_ext[1] <= op_ext[2];

  AST_A_ORDER_LT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_lt_a && v_gt_a)) else $error("value both below and above A"); // R11
  AST_B_ORDER_LT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_lt_b && v_gt_b)) else $error("value both below and above B"); // R11

endmodule

// File: rtl/adc_win_decide.sv
module adc_win_decide
  import adc_win_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_en,
  input  logic cmp_gt,
  input  logic cmp_rng,
  input  logic v_lt_a,
  input  logic v_gt_a,
  input  logic v_lt_b,
  input  logic v_gt_b,
  input  logic a_le_b,
  output logic keep
);
  win_mode_e mode;
  logic      rng_out_hit;
  logic      rng_in_hit;
  logic      cond_hit;

  assign mode = win_mode(cmp_rng, cmp_gt);

  // The range conditions swap AND/OR with the threshold order.
  assign rng_out_hit = a_le_b ? (v_lt_a | v_gt_b) : (v_lt_a & v_gt_b);
  assign rng_in_hit  = a_le_b ? (v_gt_a & v_lt_b) : (v_gt_a | v_lt_b);

  always_comb begin
    unique case (mode)
      WIN_BELOW:   cond_hit = v_lt_a;
      WIN_ABOVE:   cond_hit = v_gt_a;
      WIN_OUTSIDE: cond_hit = rng_out_hit;
      WIN_INSIDE:  cond_hit = rng_in_hit;
      default:     cond_hit = 1'b0;
    endcase
  end

  assign keep = !cmp_en | cond_hit;

  AST_RANGE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rng_out_hit, rng_in_hit})) else $error("range conditions overlap"); // R8
  AST_BYPASS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |-> keep) else $error("bypass did not keep"); // R3

endmodule

// File: rtl/adc_win_store.sv
module adc_win_store #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              keep,
  output logic              accept,
  output logic [DATA_W-1:0] result_q
);
  logic take;

  assign take = res_valid & keep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept   <= 1'b0;
      result_q <= '0;
    end else begin
      accept <= take;
      if (take) result_q <= res_data;
    end
  end

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(res_valid)) else $error("accept without valid"); // R12
  AST_ACCEPT_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> result_q == $past(res_data)) else $error("stored wrong data"); // R2
  AST_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> result_q == $past(result_q)) else $error("result moved"); // R10

endmodule

// File: rtl/adc_window_gate.sv
module adc_window_gate #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic              diff_mode,
  input  logic              cmp_en,
  input  logic              cmp_gt,
  input  logic              cmp_rng,
  input  logic [DATA_W-1:0] thr_a,
  input  logic [DATA_W-1:0] thr_b,
  output logic              accept,
  output logic [DATA_W-1:0] result_q
);
  logic v_lt_a, v_gt_a, v_lt_b, v_gt_b, a_le_b;
  logic keep;

  adc_win_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .diff_mode(diff_mode),
    .val(res_data), .thr_a(thr_a), .thr_b(thr_b),
    .v_lt_a(v_lt_a), .v_gt_a(v_gt_a), .v_lt_b(v_lt_b), .v_gt_b(v_gt_b),
    .a_le_b(a_le_b)
  );

  adc_win_decide u_decide (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .cmp_gt(cmp_gt),
    .cmp_rng(cmp_rng), .v_lt_a(v_lt_a), .v_gt_a(v_gt_a),
    .v_lt_b(v_lt_b), .v_gt_b(v_gt_b), .a_le_b(a_le_b), .keep(keep)
  );

  adc_win_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .keep(keep), .accept(accept), .result_q(result_q)
  );

  AST_FIRST_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (!accept && result_q == '0)) else $error("reset state"); // R1

endmodule

// File: tb/tb_adc_window_gate.sv
module tb_adc_window_gate;
  localparam int DW  = 4;
  localparam int NV  = 1 << DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic          diff_mode = 1'b0;
  logic          cmp_en = 1'b0;
  logic          cmp_gt = 1'b0;
  logic          cmp_rng = 1'b0;
  logic [DW-1:0] thr_a = '0;
  logic [DW-1:0] thr_b = '0;
  logic          accept;
  logic [DW-1:0] result_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_window_gate #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .diff_mode(diff_mode), .cmp_en(cmp_en), .cmp_gt(cmp_gt), .cmp_rng(cmp_rng),
    .thr_a(thr_a), .thr_b(thr_b), .accept(accept), .result_q(result_q)
  );

  function automatic int as_num(input int raw, input bit sgn);
    return (sgn && raw >= NV/2) ? raw - NV : raw;
  endfunction

  // Reference decision, written from the requirement table.
  function automatic bit ref_pass(input int v, input int a, input int b,
                                  input bit en, input bit gt, input bit rng);
    if (!en) return 1;
    if (!rng) return gt ? (v > a) : (v < a);
    if (!gt) return (a <= b) ? (v < a || v > b) : (v < a && v > b);
    return (a <= b) ? (v > a && v < b) : (v > a || v < b);
  endfunction

  function automatic string req_tag(input bit en, input bit gt, input bit rng,
                                    input bit ordered, input bit sgn);
    string t;
    if (!en) t = "R3";
    else if (!rng) t = gt ? "R5" : "R4";
    else if (!gt) t = ordered ? "R6" : "R7";
    else t = ordered ? "R8" : "R9";
    if (sgn) t = {t, " R11"};
    return t;
  endfunction

  bit            pend = 0;
  bit            exp_acc;
  logic [DW-1:0] exp_res = '0;
  string         pend_tag;

  task automatic check_pending();
    if (!pend) return;
    n_chk++;
    if (accept !== exp_acc || result_q !== exp_res) begin
      n_bad++;
      $display("FAIL %s: accept=%0b result=%0d expected accept=%0b result=%0d",
               pend_tag, accept, result_q, exp_acc, exp_res);
    end
    pend = 0;
  endtask

  // Called at a negedge: check the previous beat, then drive a new one.
  task automatic beat(input bit vld, input int v, input int a, input int b,
                      input bit sgn, input bit en, input bit gt, input bit rng);
    bit p;
    check_pending();
    res_valid = vld; res_data = DW'(v); thr_a = DW'(a); thr_b = DW'(b);
    diff_mode = sgn; cmp_en = en; cmp_gt = gt; cmp_rng = rng;
    p = ref_pass(as_num(v, sgn), as_num(a, sgn), as_num(b, sgn), en, gt, rng);
    exp_acc = vld && p;
    if (exp_acc) exp_res = DW'(v);
    if (!vld) pend_tag = "R12";
    else if (!p) pend_tag = {"R10 ", req_tag(en, gt, rng, as_num(a, sgn) <= as_num(b, sgn), sgn)};
    else pend_tag = {"R2 ", req_tag(en, gt, rng, as_num(a, sgn) <= as_num(b, sgn), sgn)};
    pend = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held.
    n_chk++;
    if (accept !== 1'b0 || result_q !== '0) begin
      n_bad++;
      $display("FAIL R1: accept=%0b result=%0d expected accept=0 result=0", accept, result_q);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (accept !== 1'b0 || result_q !== '0) begin
      n_bad++;
      $display("FAIL R1: accept=%0b result=%0d expected accept=0 result=0", accept, result_q);
    end

    // R3: compare disabled, every mode and threshold pattern accepted.
    for (int m = 0; m < 4; m++)
      for (int v = 0; v < NV; v++)
        beat(1, v, (v * 5) % NV, (v * 3 + 7) % NV, m[0], 0, m[0], m[1]);

    // R12: idle cycles with moving data and compare off.
    for (int v = 0; v < NV; v++) beat(0, v, 0, 0, 0, 0, 0, 0);

    // R4..R11: exhaustive sweep of result and both thresholds.
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < NV; a++)
          for (int b = 0; b < NV; b++)
            for (int v = 0; v < NV; v++)
              beat(1, v, a, b, s[0], 1, m[0], m[1]);

    // R12 again after a sweep, holding whatever was last stored.
    for (int v = 0; v < 4; v++) beat(0, NV - 1 - v, 0, 0, 1, 1, 0, 0);
    check_pending();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule